// File: doc/BRIEF.md
# Lock Byte Access Guard

This block keeps the protection byte of an on-chip program and data memory and rules on every access request against it. A programming port can write a new lock value or issue a chip erase. An ordinary write can only program bits (drive them from 1 to 0). Only a chip erase returns the byte to all ones. A register with an all-ones reset value stands in for storage that survives power cycles.

Two fields of the byte decide the outcome. The external field governs requests from the outside programming path: memory writes, verify reads, fuse writes and protection-bit writes. The boot field governs self-programming stores and program-memory loads aimed at the application section. The grant output and the interrupt-disable output are combinational functions of the stored byte and the request fields. The request path is a plain query with no handshake and no back-pressure: the answer is valid in the same cycle the fields are presented. The write and erase strobes are single-cycle controls that are always accepted.

Top module: `nvlock_guard`

## Requirements
- R1: After reset the lock byte reads 8'hFF and every defined request kind is granted.
- R2: A write strobe stores (old AND written) for bits 5:0, so it can only clear bits. Bits 7:6 always read as 1. The new value is visible one clock after the strobe.
- R3: A chip erase sets the byte to 8'hFF on the next clock edge. It wins over a write strobe in the same cycle. No other action raises a bit.
- R4: Request kinds are coded 0 external write, 1 external verify, 2 fuse write, 3 protection-bit write, 4 self store, 5 self load. With {bit1,bit0} = 11, kinds 0 to 3 are granted.
- R5: With {bit1,bit0} = 10, external write and fuse write are denied, while external verify and protection-bit write are granted.
- R6: With {bit1,bit0} = 00 or 01, all of kinds 0 to 3 are denied.
- R7: Target and running-section codes are 0 application and 1 boot. When bit2 is 0, self stores to the application are denied. Self stores to the boot section are always granted.
- R8: When bit3 is 0, a self load that targets the application while running from boot is denied. Loads issued from the application itself are granted.
- R9: The interrupt-disable output is high exactly when bit3 is 0, vectors sit in the boot section, and code runs from the application.
- R10: Request kind codes 6 and 7 are always denied.
- R11: Bits 5:4 are stored and read back, but they have no effect on any grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the all-ones value |
| wr_lock | input | 1 | Write-lock-byte strobe |
| wr_data | input | 8 | Value to AND into the lock byte |
| erase | input | 1 | Chip erase strobe |
| req_kind | input | 3 | Access kind code |
| req_target | input | 1 | Section addressed (0 app, 1 boot) |
| run_section | input | 1 | Section code runs from (0 app, 1 boot) |
| vec_in_boot | input | 1 | Interrupt vectors placed in boot section |
| grant | output | 1 | Request allowed |
| irq_block | output | 1 | Interrupts disabled |
| lock_q | output | 8 | Current lock byte |

## Verification
The hardest state to reach from the ports is a byte that has been pushed through several one-way transitions. In that state a raised bit would reveal a broken erase path or a broken AND path. The bench stacks writes whose patterns partly overlap, then checks that no bit returns to 1. It fires an erase and a write in the same cycle. After each state it sweeps all 32 kind, target and section combinations, so that every decode mode is seen against every request.

// File: rtl/nvlock_pkg.sv
package nvlock_pkg;
  localparam int LOCK_W      = 8;
  localparam int ACTIVE_BITS = 6;
  localparam int KIND_W      = 3;
  localparam int EXT_LO      = 0;   // external field: [EXT_LO+1:EXT_LO]
  localparam int SELF_LO     = 2;   // boot field:     [SELF_LO+1:SELF_LO]

  typedef enum logic [KIND_W-1:0] {
    ACC_EXT_WR  = 3'd0,
    ACC_EXT_VFY = 3'd1,
    ACC_FUSE_WR = 3'd2,
    ACC_PROT_WR = 3'd3,
    ACC_SELF_ST = 3'd4,
    ACC_SELF_LD = 3'd5
  } acc_kind_e;

  typedef enum logic [1:0] {
    EXT_OPEN  = 2'd0,
    EXT_WRLCK = 2'd1,
    EXT_FULL  = 2'd2
  } ext_level_e;

  localparam logic SEC_APP  = 1'b0;
  localparam logic SEC_BOOT = 1'b1;
endpackage

// File: rtl/nvlock_store.sv
module nvlock_store #(
  parameter int W      = 8,
  parameter int ACTIVE = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         erase,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < ACTIVE) begin : g_live
      logic b;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      b <= 1'b1;
        else if (erase)  b <= 1'b1;
        else if (wr)     b <= b & wdata[i];
      end
      assign q[i] = b;
    end else begin : g_tied
      assign q[i] = 1'b1;
    end
  end
endmodule

// File: rtl/nvlock_ext_dec.sv
module nvlock_ext_dec
  import nvlock_pkg::*;
(
  input  logic [1:0]        fld,
  input  logic [KIND_W-1:0] kind,
  output logic              is_ext,
  output logic              allow
);
  ext_level_e lvl;

  always_comb begin
    unique case (fld)
      2'b11:   lvl = EXT_OPEN;
      2'b10:   lvl = EXT_WRLCK;
      default: lvl = EXT_FULL;
    endcase
  end

  always_comb begin
    is_ext = 1'b1;
    allow  = 1'b0;
    case (acc_kind_e'(kind))
      ACC_EXT_WR, ACC_FUSE_WR:  allow = (lvl == EXT_OPEN);
      ACC_EXT_VFY, ACC_PROT_WR: allow = (lvl != EXT_FULL);
      default: is_ext = 1'b0;
    endcase
  end
endmodule

// File: rtl/nvlock_self_dec.sv
module nvlock_self_dec
  import nvlock_pkg::*;
(
  input  logic [1:0]        fld,
  input  logic [KIND_W-1:0] kind,
  input  logic              target,
  input  logic              running,
  input  logic              vec_boot,
  output logic              is_self,
  output logic              allow,
  output logic              irq_off
);
  logic st_block, ld_block;

  assign st_block = ~fld[0];
  assign ld_block = ~fld[1];

  always_comb begin
    is_self = 1'b1;
    allow   = 1'b0;
    case (acc_kind_e'(kind))
      ACC_SELF_ST: allow = (target == SEC_BOOT) || !st_block;
      ACC_SELF_LD: allow = !(ld_block && target == SEC_APP && running == SEC_BOOT);
      default:     is_self = 1'b0;
    endcase
  end

  assign irq_off = ld_block & vec_boot & (running == SEC_APP);
endmodule

// File: rtl/nvlock_guard.sv
module nvlock_guard
  import nvlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lock,
  input  logic [LOCK_W-1:0] wr_data,
  input  logic              erase,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              req_target,
  input  logic              run_section,
  input  logic              vec_in_boot,
  output logic              grant,
  output logic              irq_block,
  output logic [LOCK_W-1:0] lock_q
);
  logic ext_hit, ext_ok, self_hit, self_ok;

  nvlock_store #(.W(LOCK_W), .ACTIVE(ACTIVE_BITS)) store_i (
    .clk(clk), .rst_n(rst_n), .wr(wr_lock), .wdata(wr_data),
    .erase(erase), .q(lock_q)
  );

  nvlock_ext_dec ext_i (
    .fld(lock_q[EXT_LO+1:EXT_LO]), .kind(req_kind),
    .is_ext(ext_hit), .allow(ext_ok)
  );

  nvlock_self_dec self_i (
    .fld(lock_q[SELF_LO+1:SELF_LO]), .kind(req_kind),
    .target(req_target), .running(run_section), .vec_boot(vec_in_boot),
    .is_self(self_hit), .allow(self_ok), .irq_off(irq_block)
  );

  assign grant = ext_hit ? ext_ok : (self_hit ? self_ok : 1'b0);
endmodule

// File: rtl/nvlock_guard_chk.sv
module nvlock_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_lock,
  input logic       erase,
  input logic [2:0] req_kind,
  input logic       req_target,
  input logic       run_section,
  input logic       vec_in_boot,
  input logic       grant,
  input logic       irq_block,
  input logic [7:0] lock_q
);
  // R3
  erase_sets_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> lock_q == 8'hFF);
  // R3
  no_bit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> (lock_q & ~$past(lock_q)) == 8'h00);
  // R2
  top_bits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[7:6] == 2'b11);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !erase && !wr_lock |=> $stable(lock_q));
  // R5
  ext_write_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 3'd0 && lock_q[1:0] != 2'b11) |-> !grant);
  // R7
  self_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == 3'd4 && req_target == 1'b0 && !lock_q[2]) |-> !grant);
  // R9
  irq_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_block == (!lock_q[3] && vec_in_boot && run_section == 1'b0));
  // R10
  bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_kind[2:1] == 2'b11 |-> !grant);
endmodule

bind nvlock_guard nvlock_guard_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .erase(erase),
  .req_kind(req_kind), .req_target(req_target), .run_section(run_section),
  .vec_in_boot(vec_in_boot), .grant(grant), .irq_block(irq_block),
  .lock_q(lock_q)
);

// File: tb/nvlock_guard_tb.sv
`timescale 1ns/1ps
module nvlock_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_lock = 1'b0;
  logic [7:0] wr_data = 8'hFF;
  logic       erase = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic       req_target = 1'b0;
  logic       run_section = 1'b0;
  logic       vec_in_boot = 1'b0;
  logic       grant, irq_block;
  logic [7:0] lock_q;

  int checks = 0, fails = 0;
  logic [7:0] exp_lock = 8'hFF;
  bit done = 0;

  always #5 clk = ~clk;

  nvlock_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_lock(wr_lock), .wr_data(wr_data),
    .erase(erase), .req_kind(req_kind), .req_target(req_target),
    .run_section(run_section), .vec_in_boot(vec_in_boot),
    .grant(grant), .irq_block(irq_block), .lock_q(lock_q)
  );

  function automatic bit exp_grant(logic [7:0] l, logic [2:0] k, logic t, logic r);
    logic [1:0] e;
    e = l[1:0];
    case (k)
      3'd0, 3'd2: return e == 2'b11;
      3'd1, 3'd3: return e == 2'b11 || e == 2'b10;
      3'd4:       return t == 1'b1 || l[2];
      3'd5:       return !(t == 1'b0 && r == 1'b1 && !l[3]);
      default:    return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic write_lock(logic [7:0] d);
    @(negedge clk); wr_lock = 1'b1; wr_data = d;
    @(negedge clk); wr_lock = 1'b0; wr_data = 8'hFF;
    exp_lock = (exp_lock & d) | 8'hC0;
  endtask

  task automatic do_erase();
    @(negedge clk); erase = 1'b1;
    @(negedge clk); erase = 1'b0;
    exp_lock = 8'hFF;
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 8; k++)
      for (int t = 0; t < 2; t++)
        for (int r = 0; r < 2; r++) begin
          @(negedge clk);
          req_kind = 3'(k); req_target = t[0]; run_section = r[0];
          #1;
          chk(tag, {31'd0, grant}, {31'd0, exp_grant(exp_lock, 3'(k), t[0], r[0])});
        end
  endtask

  task automatic t_reset();
    #1 chk("R1 lock", lock_q, 8'hFF);
    sweep("R1 grant");
  endtask

  task automatic t_write_and();
    write_lock(8'h3F);  chk("R2 top bits", lock_q, 8'hFF);
    write_lock(8'hFA);  chk("R2 and", lock_q, 8'hFA);
    write_lock(8'hF5);  chk("R2 and again", lock_q, 8'hF0);
    write_lock(8'hFF);  chk("R3 no rise", lock_q, 8'hF0);
    write_lock(8'h00);  chk("R2 all clear", lock_q, 8'hC0);
  endtask

  task automatic t_erase();
    do_erase(); chk("R3 erase", lock_q, 8'hFF);
    write_lock(8'hC0);
    @(negedge clk); erase = 1'b1; wr_lock = 1'b1; wr_data = 8'h00;
    @(negedge clk); erase = 1'b0; wr_lock = 1'b0; wr_data = 8'hFF;
    exp_lock = 8'hFF;
    chk("R3 erase wins", lock_q, 8'hFF);
  endtask

  task automatic t_ext_modes();
    do_erase(); sweep("R4 open");
    write_lock(8'hFE); chk("R5 lock", lock_q, 8'hFE); sweep("R5 wrlock");
    do_erase(); write_lock(8'hFD); sweep("R6 mode01");
    write_lock(8'hFC); chk("R6 lock", lock_q, 8'hFC); sweep("R6 mode00");
  endtask

  task automatic t_self_modes();
    do_erase(); write_lock(8'hFB); sweep("R7 store lock");
    do_erase(); write_lock(8'hF7); sweep("R8 load lock");
    write_lock(8'hF3); sweep("R8 both");
    do_erase(); write_lock(8'hCF); chk("R11 readback", lock_q, 8'hCF);
    sweep("R11 no effect");
    for (int k = 6; k < 8; k++) begin
      @(negedge clk); req_kind = 3'(k); #1;
      chk("R10 undefined", {31'd0, grant}, 32'd0);
    end
  endtask

  task automatic t_irq();
    do_erase();
    for (int s = 0; s < 2; s++) begin
      if (s == 1) write_lock(8'hF7);
      for (int v = 0; v < 2; v++)
        for (int r = 0; r < 2; r++) begin
          @(negedge clk); vec_in_boot = v[0]; run_section = r[0]; #1;
          chk("R9 irq", {31'd0, irq_block},
              {31'd0, (s == 1 && v == 1 && r == 0)});
        end
    end
    vec_in_boot = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_and();
    t_erase();
    t_ext_modes();
    t_self_modes();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule